// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block handles in-band software flow control for one UART channel. Each received character is compared against four programmable characters: two "resume" codes (XonA, XonB) and two "stop" codes (XoffA, XoffB). A matched stop code pauses the local transmitter. A matched resume code lets it run again. Matched flow characters are removed from the received stream, and every other character is forwarded to the receive FIFO write port one cycle later.

On the transmit side, the block watches two level flags from the local receive FIFO. When the FIFO reaches its trigger level, it asks the transmitter to insert a stop code. Once the FIFO has drained below its low threshold, it asks for a resume code. Each request is made once per crossing. The transmitter takes characters through a request/acknowledge handshake.

A 4-bit mode field selects the behaviour. Bits 3:2 choose what is transmitted and bits 1:0 choose what is compared on receive; the two halves are independent. A separate special-character mode flags any received character equal to XoffB. In that mode the character is still passed to the FIFO. This mode is honoured only while the whole mode field is zero.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: Out of reset, `tx_pause`, `fifo_wr`, `ins_req` and `spcl_flag` are all low.
- R2: Receive select `cfg_mode[1:0]` = 2'b10 compares against XonA/XoffA, and 2'b01 compares against XonB/XoffB. A matching stop code sets `tx_pause` and a matching resume code clears it. The change is visible one clock after the `rx_valid` edge, and the matched character is not written to the FIFO.
- R3: Receive select 2'b11 acts only on a pair: XoffA followed by XoffB pauses, and XonA followed by XonB resumes. The first character of a pair is held as pending and is not written. If the next character is not the expected second one, the pending state is dropped and the new character is judged as a fresh first character.
- R4: A character that is not consumed as a flow character is presented on `fifo_wr_data` with `fifo_wr` high for one cycle, one clock after it was accepted. With receive select 2'b00, every character passes and `tx_pause` is cleared and stays low.
- R5: Transmit select `cfg_mode[3:2]` = 2'b10 inserts XoffA/XonA, and 2'b01 inserts XoffB/XonB, as a single character.
- R6: Transmit select 2'b11 inserts a pair, A first and then B (XoffA then XoffB, or XonA then XonB).
- R7: A stop request is made once when `fifo_at_trig` is high and no stop is outstanding. A resume request is made only after a stop was sent and `fifo_below_low` is high. No request repeats while its flag stays high. Transmit select 2'b00 makes no requests.
- R8: Once raised, `ins_req` stays high with `ins_char` stable until the clock edge at which `ins_ack` is high. The next character or idle state follows in the next cycle.
- R9: With `cfg_spcl_en` high and `cfg_mode` = 4'b0000, a received character equal to XoffB sets `spcl_flag` and is still written to the FIFO. The flag stays set until `spcl_clr`, and a new match in the same cycle as `spcl_clr` wins.
- R10: While any bit of `cfg_mode` is set, special-character detection never sets `spcl_flag`.
- R11: Transmit and receive selects combine freely. For example, receive pair matching works with transmit select 2'b00. Bit 0 of each programmed character matches bit 0 of the received character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 4 | [3:2] transmit select, [1:0] receive select |
| cfg_spcl_en | input | 1 | Special-character detect enable |
| cfg_xon_a | input | 8 | Resume code A |
| cfg_xon_b | input | 8 | Resume code B |
| cfg_xoff_a | input | 8 | Stop code A |
| cfg_xoff_b | input | 8 | Stop code B, also the special character |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | 8 | Received character |
| spcl_clr | input | 1 | Clears the special-character flag |
| fifo_at_trig | input | 1 | Receive FIFO at or above trigger level |
| fifo_below_low | input | 1 | Receive FIFO below low threshold |
| ins_ack | input | 1 | Transmitter took `ins_char` |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_wr_data | output | 8 | Receive FIFO write data |
| tx_pause | output | 1 | Hold the local transmitter after the current character |
| spcl_flag | output | 1 | Special character seen |
| ins_req | output | 1 | Request to insert a flow character |
| ins_char | output | 8 | Flow character to insert |

## Verification
The bench breaks pair sequences on purpose: a stop-A followed by an ordinary byte and then a lone stop-B must not pause. A design that kept the pending state across the break would pause wrongly. The bench also holds the trigger flag high for several cycles after a stop was sent. A design that repeated the request would flood the link. Resume without an earlier stop and a held-off acknowledge are also exercised, which exposes a design that drops or changes the inserted character. Special-character detect is run with the mode field zero and non-zero, which catches a design that flags in flow-control mode or swallows the matched byte.

// File: rtl/xonxoff_pkg.sv
package xonxoff_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_B    = 2'b01,
    SEL_A    = 2'b10,
    SEL_PAIR = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'b00,
    PEND_STOP = 2'b01,
    PEND_GO   = 2'b10
  } pend_e;

  typedef enum logic [1:0] {
    INS_IDLE   = 2'b00,
    INS_FIRST  = 2'b01,
    INS_SECOND = 2'b10
  } ins_state_e;
endpackage

// File: rtl/xonxoff_rx_match.sv
module xonxoff_rx_match
  import xonxoff_pkg::*;
#(
  parameter int unsigned W = CHAR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sel_e         rx_sel,
  input  logic         spcl_allow,
  input  logic [W-1:0] xon_a,
  input  logic [W-1:0] xon_b,
  input  logic [W-1:0] xoff_a,
  input  logic [W-1:0] xoff_b,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic         spcl_clr,
  output logic         fifo_wr,
  output logic [W-1:0] fifo_wr_data,
  output logic         tx_pause,
  output logic         spcl_flag
);
  pend_e        pend_q, pend_n;
  logic         pause_q, pause_n;
  logic         spcl_q, spcl_n;
  logic         wr_q, wr_n;
  logic [W-1:0] data_q;
  logic         keep;
  logic [W-1:0] stop_c, go_c;

  assign stop_c = (rx_sel == SEL_B) ? xoff_b : xoff_a;
  assign go_c   = (rx_sel == SEL_B) ? xon_b  : xon_a;

  always_comb begin
    keep    = 1'b1;
    pend_n  = pend_q;
    pause_n = pause_q;
    spcl_n  = spcl_q & ~spcl_clr;
    if (rx_sel == SEL_NONE) begin
      pause_n = 1'b0;
      pend_n  = PEND_NONE;
    end
    if (rx_valid) begin
      unique case (rx_sel)
        SEL_A, SEL_B: begin
          if (rx_data == stop_c) begin
            keep    = 1'b0;
            pause_n = 1'b1;
          end else if (rx_data == go_c) begin
            keep    = 1'b0;
            pause_n = 1'b0;
          end
        end
        SEL_PAIR: begin
          pend_n = PEND_NONE;
          if (pend_q == PEND_STOP && rx_data == xoff_b) begin
            keep    = 1'b0;
            pause_n = 1'b1;
          end else if (pend_q == PEND_GO && rx_data == xon_b) begin
            keep    = 1'b0;
            pause_n = 1'b0;
          end else if (rx_data == xoff_a) begin
            keep   = 1'b0;
            pend_n = PEND_STOP;
          end else if (rx_data == xon_a) begin
            keep   = 1'b0;
            pend_n = PEND_GO;
          end
        end
        default: begin
          if (spcl_allow && rx_data == xoff_b) spcl_n = 1'b1;
        end
      endcase
    end
    wr_n = rx_valid & keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= PEND_NONE;
      pause_q <= 1'b0;
      spcl_q  <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      pend_q  <= pend_n;
      pause_q <= pause_n;
      spcl_q  <= spcl_n;
      wr_q    <= wr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (rx_valid) data_q <= rx_data;
  end

  assign fifo_wr      = wr_q;
  assign fifo_wr_data = data_q;
  assign tx_pause     = pause_q;
  assign spcl_flag    = spcl_q;
endmodule

// File: rtl/xonxoff_tx_insert.sv
module xonxoff_tx_insert
  import xonxoff_pkg::*;
#(
  parameter int unsigned W = CHAR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sel_e         tx_sel,
  input  logic [W-1:0] xon_a,
  input  logic [W-1:0] xon_b,
  input  logic [W-1:0] xoff_a,
  input  logic [W-1:0] xoff_b,
  input  logic         at_trig,
  input  logic         below_low,
  input  logic         ins_ack,
  output logic         ins_req,
  output logic [W-1:0] ins_char
);
  ins_state_e st_q, st_n;
  logic       stop_kind_q, stop_kind_n;
  logic       stop_out_q, stop_out_n;
  logic [W-1:0] code_a, code_b;

  assign code_a = stop_kind_q ? xoff_a : xon_a;
  assign code_b = stop_kind_q ? xoff_b : xon_b;

  always_comb begin
    st_n        = st_q;
    stop_kind_n = stop_kind_q;
    stop_out_n  = stop_out_q;
    unique case (st_q)
      INS_IDLE: begin
        if (tx_sel == SEL_NONE) begin
          stop_out_n = 1'b0;
        end else if (at_trig && !stop_out_q) begin
          stop_kind_n = 1'b1;
          st_n        = INS_FIRST;
        end else if (below_low && stop_out_q) begin
          stop_kind_n = 1'b0;
          st_n        = INS_FIRST;
        end
      end
      INS_FIRST: begin
        if (ins_ack) begin
          if (tx_sel == SEL_PAIR) begin
            st_n = INS_SECOND;
          end else begin
            st_n       = INS_IDLE;
            stop_out_n = stop_kind_q;
          end
        end
      end
      default: begin
        if (ins_ack) begin
          st_n       = INS_IDLE;
          stop_out_n = stop_kind_q;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= INS_IDLE;
      stop_kind_q <= 1'b0;
      stop_out_q  <= 1'b0;
    end else begin
      st_q        <= st_n;
      stop_kind_q <= stop_kind_n;
      stop_out_q  <= stop_out_n;
    end
  end

  assign ins_req  = (st_q != INS_IDLE);
  assign ins_char = (st_q == INS_SECOND || (st_q == INS_FIRST && tx_sel == SEL_B))
                    ? code_b : code_a;
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl
  import xonxoff_pkg::*;
#(
  parameter int unsigned W = CHAR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   cfg_mode,
  input  logic         cfg_spcl_en,
  input  logic [W-1:0] cfg_xon_a,
  input  logic [W-1:0] cfg_xon_b,
  input  logic [W-1:0] cfg_xoff_a,
  input  logic [W-1:0] cfg_xoff_b,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic         spcl_clr,
  input  logic         fifo_at_trig,
  input  logic         fifo_below_low,
  input  logic         ins_ack,
  output logic         fifo_wr,
  output logic [W-1:0] fifo_wr_data,
  output logic         tx_pause,
  output logic         spcl_flag,
  output logic         ins_req,
  output logic [W-1:0] ins_char
);
  sel_e tx_sel, rx_sel;
  logic spcl_allow;

  assign tx_sel     = sel_e'(cfg_mode[3:2]);
  assign rx_sel     = sel_e'(cfg_mode[1:0]);
  assign spcl_allow = cfg_spcl_en & (cfg_mode == 4'b0000);

  xonxoff_rx_match #(.W(W)) rx_i (
    .clk(clk), .rst_n(rst_n), .rx_sel(rx_sel), .spcl_allow(spcl_allow),
    .xon_a(cfg_xon_a), .xon_b(cfg_xon_b), .xoff_a(cfg_xoff_a), .xoff_b(cfg_xoff_b),
    .rx_valid(rx_valid), .rx_data(rx_data), .spcl_clr(spcl_clr),
    .fifo_wr(fifo_wr), .fifo_wr_data(fifo_wr_data),
    .tx_pause(tx_pause), .spcl_flag(spcl_flag)
  );

  xonxoff_tx_insert #(.W(W)) tx_i (
    .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel),
    .xon_a(cfg_xon_a), .xon_b(cfg_xon_b), .xoff_a(cfg_xoff_a), .xoff_b(cfg_xoff_b),
    .at_trig(fifo_at_trig), .below_low(fifo_below_low), .ins_ack(ins_ack),
    .ins_req(ins_req), .ins_char(ins_char)
  );
endmodule

// File: rtl/xonxoff_flow_ctrl_chk.sv
module xonxoff_flow_ctrl_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   cfg_mode,
  input logic [W-1:0] cfg_xoff_a,
  input logic         rx_valid,
  input logic [W-1:0] rx_data,
  input logic         ins_ack,
  input logic         fifo_wr,
  input logic         tx_pause,
  input logic         spcl_flag,
  input logic         ins_req,
  input logic [W-1:0] ins_char
);
  // R2: stop code A in single-A receive mode pauses and is not written
  a_r2_stop_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[1:0] == 2'b10 && rx_valid && rx_data == cfg_xoff_a) |=> (tx_pause && !fifo_wr));

  // R4: a FIFO write only follows an accepted character
  a_r4_wr_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(rx_valid));

  // R2: pause only rises in response to a received character
  a_r2_pause_from_rx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pause) |-> $past(rx_valid));

  // R8: request held with stable character until acknowledged
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !ins_ack) |=> (ins_req && $stable(ins_char)));

  // R7: no transmit select, no new request
  a_r7_no_tx_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[3:2] == 2'b00 && !ins_req) |=> !ins_req);

  // R10: flag only rises while the mode field is zero
  a_r10_spcl_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spcl_flag) |-> ($past(cfg_mode) == 4'b0000));
endmodule

bind xonxoff_flow_ctrl xonxoff_flow_ctrl_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_xoff_a(cfg_xoff_a),
  .rx_valid(rx_valid), .rx_data(rx_data), .ins_ack(ins_ack),
  .fifo_wr(fifo_wr), .tx_pause(tx_pause), .spcl_flag(spcl_flag),
  .ins_req(ins_req), .ins_char(ins_char)
);

// File: tb/xonxoff_flow_ctrl_tb.sv
module xonxoff_flow_ctrl_tb_top;
  localparam logic [7:0] XON_A  = 8'h11;
  localparam logic [7:0] XOFF_A = 8'h13;
  localparam logic [7:0] XON_B  = 8'h90;
  localparam logic [7:0] XOFF_B = 8'h93;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cfg_mode;
  logic       cfg_spcl_en;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       spcl_clr, fifo_at_trig, fifo_below_low, ins_ack;
  logic       fifo_wr, tx_pause, spcl_flag, ins_req;
  logic [7:0] fifo_wr_data, ins_char;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xonxoff_flow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_spcl_en(cfg_spcl_en),
    .cfg_xon_a(XON_A), .cfg_xon_b(XON_B), .cfg_xoff_a(XOFF_A), .cfg_xoff_b(XOFF_B),
    .rx_valid(rx_valid), .rx_data(rx_data), .spcl_clr(spcl_clr),
    .fifo_at_trig(fifo_at_trig), .fifo_below_low(fifo_below_low), .ins_ack(ins_ack),
    .fifo_wr(fifo_wr), .fifo_wr_data(fifo_wr_data), .tx_pause(tx_pause),
    .spcl_flag(spcl_flag), .ins_req(ins_req), .ins_char(ins_char)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one received character; return at the negedge where results show
  task automatic rx_char(input logic [7:0] d);
    rx_valid = 1'b1;
    rx_data  = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_mode = 4'b0; cfg_spcl_en = 1'b0; rx_valid = 1'b0; rx_data = '0;
    spcl_clr = 1'b0; fifo_at_trig = 1'b0; fifo_below_low = 1'b0; ins_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 pause", {7'b0, tx_pause}, 8'h0);
    chk("R1 wr", {7'b0, fifo_wr}, 8'h0);
    chk("R1 req", {7'b0, ins_req}, 8'h0);
    chk("R1 flag", {7'b0, spcl_flag}, 8'h0);
  endtask

  task automatic t_single();
    cfg_mode = 4'b0010;
    rx_char(XOFF_A);
    chk("R2 A stop pause", {7'b0, tx_pause}, 8'h1);
    chk("R2 A stop not written", {7'b0, fifo_wr}, 8'h0);
    rx_char(8'h41);
    chk("R4 data written", {7'b0, fifo_wr}, 8'h1);
    chk("R4 data value", fifo_wr_data, 8'h41);
    chk("R4 pause kept", {7'b0, tx_pause}, 8'h1);
    rx_char(XOFF_B);
    chk("R2 B code passes in A mode", {7'b0, fifo_wr}, 8'h1);
    rx_char(XON_A);
    chk("R2 A resume", {7'b0, tx_pause}, 8'h0);
    chk("R2 A resume not written", {7'b0, fifo_wr}, 8'h0);
    cfg_mode = 4'b0001;
    rx_char(XOFF_A);
    chk("R2 A code passes in B mode", {7'b0, tx_pause}, 8'h0);
    rx_char(XOFF_B);
    chk("R2 B stop pause", {7'b0, tx_pause}, 8'h1);
    // R11: code differing only in bit 0 must not match
    rx_char(XON_B ^ 8'h01);
    chk("R11 bit0 mismatch", {7'b0, tx_pause}, 8'h1);
    rx_char(XON_B);
    chk("R2 B resume", {7'b0, tx_pause}, 8'h0);
  endtask

  task automatic t_pair();
    cfg_mode = 4'b0011; // R11: pair receive with no transmit select
    rx_char(XOFF_A);
    chk("R3 first held", {7'b0, fifo_wr}, 8'h0);
    chk("R3 first no pause", {7'b0, tx_pause}, 8'h0);
    rx_char(8'h55);
    chk("R3 break written", fifo_wr_data, 8'h55);
    rx_char(XOFF_B);
    chk("R3 lone second no pause", {7'b0, tx_pause}, 8'h0);
    rx_char(XOFF_A);
    rx_char(XOFF_B);
    chk("R3 pair pauses", {7'b0, tx_pause}, 8'h1);
    chk("R3 second not written", {7'b0, fifo_wr}, 8'h0);
    rx_char(XON_A);
    rx_char(XON_B);
    chk("R3 pair resumes", {7'b0, tx_pause}, 8'h0);
    rx_char(XOFF_A);
    rx_char(XOFF_B);
    cfg_mode = 4'b0000;
    @(negedge clk);
    chk("R4 select none clears pause", {7'b0, tx_pause}, 8'h0);
    rx_char(XOFF_A);
    chk("R4 none passes stop", {7'b0, fifo_wr}, 8'h1);
    chk("R4 none no pause", {7'b0, tx_pause}, 8'h0);
  endtask

  task automatic ack_once();
    ins_ack = 1'b1;
    @(negedge clk);
    ins_ack = 1'b0;
  endtask

  task automatic t_tx_single(input logic [1:0] sel, input logic [7:0] stop_c, input logic [7:0] go_c);
    cfg_mode = {sel, 2'b00};
    fifo_below_low = 1'b1;
    @(negedge clk);
    chk("R7 no resume before stop", {7'b0, ins_req}, 8'h0);
    fifo_below_low = 1'b0;
    fifo_at_trig = 1'b1;
    @(negedge clk);
    chk("R5 stop req", {7'b0, ins_req}, 8'h1);
    chk("R5 stop char", ins_char, stop_c);
    repeat (2) @(negedge clk);
    chk("R8 held req", {7'b0, ins_req}, 8'h1);
    chk("R8 held char", ins_char, stop_c);
    ack_once();
    chk("R5 done after ack", {7'b0, ins_req}, 8'h0);
    repeat (3) @(negedge clk);
    chk("R7 no repeat stop", {7'b0, ins_req}, 8'h0);
    fifo_at_trig = 1'b0;
    fifo_below_low = 1'b1;
    @(negedge clk);
    chk("R5 resume req", {7'b0, ins_req}, 8'h1);
    chk("R5 resume char", ins_char, go_c);
    ack_once();
    repeat (2) @(negedge clk);
    chk("R7 no repeat resume", {7'b0, ins_req}, 8'h0);
    fifo_below_low = 1'b0;
  endtask

  task automatic t_tx_pair();
    cfg_mode = 4'b1100;
    fifo_at_trig = 1'b1;
    @(negedge clk);
    chk("R6 first stop", ins_char, XOFF_A);
    ack_once();
    chk("R6 second req", {7'b0, ins_req}, 8'h1);
    chk("R6 second stop", ins_char, XOFF_B);
    ack_once();
    chk("R6 pair done", {7'b0, ins_req}, 8'h0);
    fifo_at_trig = 1'b0;
    fifo_below_low = 1'b1;
    @(negedge clk);
    chk("R6 first resume", ins_char, XON_A);
    ack_once();
    chk("R6 second resume", ins_char, XON_B);
    ack_once();
    chk("R6 resume done", {7'b0, ins_req}, 8'h0);
    fifo_below_low = 1'b0;
    cfg_mode = 4'b0000;
    fifo_at_trig = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 no tx select no req", {7'b0, ins_req}, 8'h0);
    fifo_at_trig = 1'b0;
  endtask

  task automatic t_special();
    cfg_spcl_en = 1'b1;
    cfg_mode = 4'b0000;
    rx_char(8'h20);
    chk("R9 non-match no flag", {7'b0, spcl_flag}, 8'h0);
    rx_char(XOFF_B);
    chk("R9 flag set", {7'b0, spcl_flag}, 8'h1);
    chk("R9 char written", fifo_wr_data, XOFF_B);
    chk("R9 write strobe", {7'b0, fifo_wr}, 8'h1);
    repeat (2) @(negedge clk);
    chk("R9 flag sticky", {7'b0, spcl_flag}, 8'h1);
    spcl_clr = 1'b1;
    @(negedge clk);
    spcl_clr = 1'b0;
    chk("R9 flag cleared", {7'b0, spcl_flag}, 8'h0);
    spcl_clr = 1'b1;
    rx_char(XOFF_B);
    spcl_clr = 1'b0;
    chk("R9 set wins over clear", {7'b0, spcl_flag}, 8'h1);
    spcl_clr = 1'b1;
    @(negedge clk);
    spcl_clr = 1'b0;
    cfg_mode = 4'b1000;
    rx_char(XOFF_B);
    chk("R10 no flag with tx select", {7'b0, spcl_flag}, 8'h0);
    cfg_mode = 4'b0001;
    rx_char(XOFF_B);
    chk("R10 no flag with rx select", {7'b0, spcl_flag}, 8'h0);
    cfg_spcl_en = 1'b0;
    cfg_mode = 4'b0000;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_single();
    t_pair();
    t_tx_single(2'b10, XOFF_A, XON_A);
    t_tx_single(2'b01, XOFF_B, XON_B);
    t_tx_pair();
    t_special();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule